// File: doc/BRIEF.md
# Bus Machine-Cycle T-State Sequencer

This block produces the clock-by-clock timing of the external bus cycles of a small 8-bit processor core. The core asks for a cycle by raising `req_valid` with a cycle type, an address and, for writes, a data byte. The sequencer then walks through the T-states of that cycle. It drives the address latch strobe, the read, write and interrupt-acknowledge strobes, the three status lines, the upper address byte and the shared low address/data byte. A slow device can stretch a cycle by pulling `ready` low, and the sequencer then holds in wait states.

A request is taken only while the sequencer is idle, or in the last T-state of the cycle in progress. A request that is still present at that last T-state starts the next cycle with no gap, so an instruction such as a register-pair add appears as one unbroken run of T-states. Once taken, the request fields are held inside the block for the whole cycle. Changing the inputs mid-cycle therefore has no effect.

A separate active-low reset request input is filtered so that only a low level held for at least `RST_MIN` clocks counts. An accepted reset abandons any cycle, parks the bus in its idle state and raises a reset output that is aligned to the clock. `rst` is the ordinary synchronous active-high reset of the clock domain. Every output is registered.

Top module: `mcyc_seq`

## Requirements
- R1: The status lines {io_m, s1, s0} carry a fixed code for the whole cycle: opcode fetch (type 0) 011, memory read (type 1) 010, memory write (type 2) 001, I/O read (type 3) 110, I/O write (type 4) 101, interrupt acknowledge (type 5) 111. Bus idle (types 6 and 7) and the idle state both show 000.
- R2: `ale` is high only in T1, and only for cycle types other than bus idle.
- R3: Types 1 to 7 last three T-states plus any wait states. An opcode fetch lasts four T-states, or six when `req_long` was high at the start. A request present in the last T-state starts the next T1 on the following clock, so a four-state fetch followed by two bus idle cycles occupies 10 consecutive T-states.
- R4: `rd_n` is low in T2 and in wait states of opcode fetch, memory read and I/O read, and high otherwise. `inta_n` follows the same timing for interrupt acknowledge only. At most one of `rd_n`, `wr_n` and `inta_n` is low.
- R5: `wr_n` is low in T2 and in wait states of memory write and I/O write. `ad_oe` is high with `ad_out` = address bits [7:0] in T1 of every non-idle cycle, and with `ad_out` = write data from T2 through T3 of writes. Otherwise `ad_oe` is low and `ad_out` is 0.
- R6: `ready` sampled low on the clock that ends T2, or ends a wait state, leads to a wait state (TW). TW can follow only T2 or TW. Bus idle cycles ignore `ready`.
- R7: `rst_in_n` low for fewer than `RST_MIN` (3) consecutive clocks has no effect. On the third consecutive low sample, `rst_out` goes high and the sequencer is forced idle with all strobes inactive; this holds while the input stays low.
- R8: On the first clock that samples `rst_in_n` high again, `rst_out` falls, and a pending request starts T1 on that same clock.
- R9: `a_hi` carries address bits [15:8] during every T-state of a non-idle cycle, and is 0 in bus idle cycles and when idle.
- R10: `t_state` reports the current T-state: 0 idle, 1 to 6 for T1 to T6, 7 for a wait state. After `rst` the outputs show idle: `t_state` 0, strobes high, `ale` low, `rst_out` low.
- R11: Request inputs are sampled only when a cycle can start. Changing them during a cycle does not change that cycle's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset of the clock domain |
| rst_in_n | input | 1 | Active-low reset request, filtered for minimum length |
| req_valid | input | 1 | A cycle is requested |
| req_type | input | 3 | Cycle type code (see R1) |
| req_long | input | 1 | Opcode fetch takes six T-states instead of four |
| req_addr | input | ADDR_W | Cycle address |
| req_wdata | input | DATA_W | Write data |
| ready | input | 1 | Device ready; low inserts wait states |
| rst_out | output | 1 | High while the accepted reset is in effect |
| t_state | output | 3 | Current T-state code |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt-acknowledge strobe, active low |
| io_m | output | 1 | Status: I/O (1) or memory (0) |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| a_hi | output | ADDR_W-DATA_W | Upper address byte |
| ad_out | output | DATA_W | Low address / write data |
| ad_oe | output | 1 | Drive enable for `ad_out` |

## Verification
A wrong T-state register shows at once as a `t_state` code that breaks the order T1, T2, (TW), T3, (T4 to T6). The strobes and `ale` are decoded from the same next state, so they are off on that same clock. A wrong latched cycle type changes the status code and the choice of strobe for the rest of the cycle. It is caught on the first T-state after the cycle starts. A miscounting reset filter shows as `rst_out` rising one clock early or late, or as a cycle cut short by a glitch. Because the bench model is compared on every clock, any of these is reported within one cycle.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  typedef enum logic [2:0] {
    CY_OPF   = 3'd0,
    CY_MRD   = 3'd1,
    CY_MWR   = 3'd2,
    CY_IORD  = 3'd3,
    CY_IOWR  = 3'd4,
    CY_INTA  = 3'd5,
    CY_BIDLE = 3'd6,
    CY_RSV   = 3'd7
  } cyc_e;

  typedef enum logic [2:0] {
    TS_I = 3'd0,
    TS_1 = 3'd1,
    TS_2 = 3'd2,
    TS_3 = 3'd3,
    TS_4 = 3'd4,
    TS_5 = 3'd5,
    TS_6 = 3'd6,
    TS_W = 3'd7
  } ts_e;

  function automatic logic is_bidle(cyc_e c);
    return (c == CY_BIDLE) || (c == CY_RSV);
  endfunction

  function automatic logic is_rd(cyc_e c);
    return (c == CY_OPF) || (c == CY_MRD) || (c == CY_IORD);
  endfunction

  function automatic logic is_wr(cyc_e c);
    return (c == CY_MWR) || (c == CY_IOWR);
  endfunction

  // {io_m, s1, s0}
  function automatic logic [2:0] status_of(cyc_e c);
    logic [2:0] s;
    case (c)
      CY_OPF:  s = 3'b011;
      CY_MRD:  s = 3'b010;
      CY_MWR:  s = 3'b001;
      CY_IORD: s = 3'b110;
      CY_IOWR: s = 3'b101;
      CY_INTA: s = 3'b111;
      default: s = 3'b000;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/mcs_rst_filter.sv
module mcs_rst_filter #(
  parameter int MIN_LOW = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_in_n,
  output logic rst_now,
  output logic rst_out
);
  localparam int CW = $clog2(MIN_LOW + 1);

  logic [CW-1:0] cnt_q;
  logic [CW:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign rst_now = !rst_in_n && (rst_out || (cnt_inc >= (CW+1)'(MIN_LOW)));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      rst_out <= 1'b0;
    end else begin
      if (rst_in_n)
        cnt_q <= '0;
      else if (cnt_q != CW'(MIN_LOW))
        cnt_q <= cnt_q + 1'b1;
      rst_out <= rst_now;
    end
  end
endmodule

// File: rtl/mcs_tstate_fsm.sv
module mcs_tstate_fsm
  import mcs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold_idle,
  input  logic          req_valid,
  input  cyc_e          req_type,
  input  logic          req_long,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          ready,
  output ts_e           st_q,
  output ts_e           st_nx,
  output cyc_e          ty_nx,
  output logic [AW-1:0] addr_nx,
  output logic [DW-1:0] wd_nx
);
  cyc_e          ty_q;
  logic          lng_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q;
  logic          last, start, go_on;

  always_comb begin
    last  = ((st_q == TS_3) && (ty_q != CY_OPF)) ||
            ((st_q == TS_4) && !lng_q) ||
            (st_q == TS_6);
    start = req_valid && !hold_idle && ((st_q == TS_I) || last);
    go_on = ready || is_bidle(ty_q);
    case (st_q)
      TS_I:       st_nx = start ? TS_1 : TS_I;
      TS_1:       st_nx = TS_2;
      TS_2, TS_W: st_nx = go_on ? TS_3 : TS_W;
      TS_3:       st_nx = (ty_q == CY_OPF) ? TS_4 : (start ? TS_1 : TS_I);
      TS_4:       st_nx = lng_q ? TS_5 : (start ? TS_1 : TS_I);
      TS_5:       st_nx = TS_6;
      TS_6:       st_nx = start ? TS_1 : TS_I;
      default:    st_nx = TS_I;
    endcase
    if (hold_idle) st_nx = TS_I;
    ty_nx   = start ? req_type  : ty_q;
    addr_nx = start ? req_addr  : addr_q;
    wd_nx   = start ? req_wdata : wd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= TS_I;
      ty_q   <= CY_BIDLE;
      lng_q  <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
    end else begin
      st_q <= st_nx;
      if (start) begin
        ty_q   <= req_type;
        lng_q  <= req_long;
        addr_q <= req_addr;
        wd_q   <= req_wdata;
      end
    end
  end
endmodule

// File: rtl/mcs_bus_drive.sv
module mcs_bus_drive
  import mcs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  ts_e              st_nx,
  input  cyc_e             ty_nx,
  input  logic [AW-1:0]    addr_nx,
  input  logic [DW-1:0]    wd_nx,
  output logic             ale,
  output logic             rd_n,
  output logic             wr_n,
  output logic             inta_n,
  output logic [2:0]       stat,
  output logic [AW-DW-1:0] a_hi,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe
);
  localparam int HW = AW - DW;

  logic          busy, bus_on, strobe_win, oe_nx;
  logic [DW-1:0] ad_nx;

  always_comb begin
    busy       = (st_nx != TS_I);
    bus_on     = busy && !is_bidle(ty_nx);
    strobe_win = (st_nx == TS_2) || (st_nx == TS_W);
    oe_nx      = bus_on && ((st_nx == TS_1) || (is_wr(ty_nx) && (st_nx != TS_1)));
    if (!oe_nx)            ad_nx = '0;
    else if (st_nx == TS_1) ad_nx = addr_nx[DW-1:0];
    else                   ad_nx = wd_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale    <= 1'b0;
      rd_n   <= 1'b1;
      wr_n   <= 1'b1;
      inta_n <= 1'b1;
      stat   <= 3'b000;
      a_hi   <= '0;
      ad_out <= '0;
      ad_oe  <= 1'b0;
    end else begin
      ale    <= bus_on && (st_nx == TS_1);
      rd_n   <= !(strobe_win && busy && is_rd(ty_nx));
      wr_n   <= !(strobe_win && busy && is_wr(ty_nx));
      inta_n <= !(strobe_win && busy && (ty_nx == CY_INTA));
      stat   <= busy ? status_of(ty_nx) : 3'b000;
      a_hi   <= bus_on ? addr_nx[AW-1:DW] : HW'(0);
      ad_out <= ad_nx;
      ad_oe  <= oe_nx;
    end
  end
endmodule

// File: rtl/mcyc_seq.sv
module mcyc_seq
  import mcs_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int RST_MIN = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rst_in_n,
  input  logic                     req_valid,
  input  logic [2:0]               req_type,
  input  logic                     req_long,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     ready,
  output logic                     rst_out,
  output logic [2:0]               t_state,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     inta_n,
  output logic                     io_m,
  output logic                     s1,
  output logic                     s0,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe
);
  logic              rst_now;
  ts_e               st_q, st_nx;
  cyc_e              ty_nx;
  logic [ADDR_W-1:0] addr_nx;
  logic [DATA_W-1:0] wd_nx;
  logic [2:0]        stat;

  mcs_rst_filter #(.MIN_LOW(RST_MIN)) u_rst (
    .clk(clk), .rst(rst), .rst_in_n(rst_in_n),
    .rst_now(rst_now), .rst_out(rst_out)
  );

  mcs_tstate_fsm #(.AW(ADDR_W), .DW(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .hold_idle(rst_now),
    .req_valid(req_valid), .req_type(cyc_e'(req_type)), .req_long(req_long),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
    .st_q(st_q), .st_nx(st_nx), .ty_nx(ty_nx), .addr_nx(addr_nx), .wd_nx(wd_nx)
  );

  mcs_bus_drive #(.AW(ADDR_W), .DW(DATA_W)) u_drv (
    .clk(clk), .rst(rst), .st_nx(st_nx), .ty_nx(ty_nx),
    .addr_nx(addr_nx), .wd_nx(wd_nx),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .stat(stat),
    .a_hi(a_hi), .ad_out(ad_out), .ad_oe(ad_oe)
  );

  assign t_state = st_q;
  assign io_m    = stat[2];
  assign s1      = stat[1];
  assign s0      = stat[0];
endmodule

// File: rtl/mcyc_seq_chk.sv
module mcyc_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       rst_out,
  input logic [2:0] t_state,
  input logic       ale,
  input logic       rd_n,
  input logic       wr_n,
  input logic       inta_n,
  input logic       io_m,
  input logic       s1,
  input logic       s0
);
  p_status_stable_r1: assert property (@(posedge clk) disable iff (rst)
    (t_state >= 3'd2) |-> $stable({io_m, s1, s0}));

  p_ale_in_t1_r2: assert property (@(posedge clk) disable iff (rst)
    ale |-> (t_state == 3'd1));

  p_t4_after_t3_r3: assert property (@(posedge clk) disable iff (rst)
    (t_state == 3'd4) |-> ($past(t_state) == 3'd3));

  p_one_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    $countones({~rd_n, ~wr_n, ~inta_n}) <= 1);

  p_wait_follows_t2_r6: assert property (@(posedge clk) disable iff (rst)
    (t_state == 3'd7) |-> ($past(t_state) == 3'd2 || $past(t_state) == 3'd7));

  p_reset_parks_bus_r7: assert property (@(posedge clk) disable iff (rst)
    rst_out |-> (t_state == 3'd0 && rd_n && wr_n && inta_n && !ale));
endmodule

bind mcyc_seq mcyc_seq_chk i_mcyc_seq_chk (
  .clk(clk), .rst(rst), .rst_out(rst_out), .t_state(t_state), .ale(ale),
  .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .io_m(io_m), .s1(s1), .s0(s0)
);

// File: tb/test_mcyc_seq.sv
`timescale 1ns/1ps
module test_mcyc_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rst_in_n = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_type = 3'd0;
  logic        req_long = 1'b0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0]  req_wdata = 8'h0;
  logic        ready = 1'b1;
  logic        rst_out, ale, rd_n, wr_n, inta_n, io_m, s1, s0, ad_oe;
  logic [2:0]  t_state;
  logic [7:0]  a_hi, ad_out;

  int checks = 0;
  int errors = 0;
  int busy_n = 0;
  int wait_n = 0;

  // reference model state
  bit          m_act = 0, m_wait = 0, m_rst = 0, m_lng = 0;
  int          m_t = 0, m_low = 0;
  logic [2:0]  m_ty = 3'd6;
  logic [15:0] m_addr = 16'h0;
  logic [7:0]  m_wd = 8'h0;

  always #10 clk = ~clk;

  mcyc_seq i_mcyc_seq (
    .clk(clk), .rst(rst), .rst_in_n(rst_in_n), .req_valid(req_valid),
    .req_type(req_type), .req_long(req_long), .req_addr(req_addr),
    .req_wdata(req_wdata), .ready(ready), .rst_out(rst_out), .t_state(t_state),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .io_m(io_m),
    .s1(s1), .s0(s0), .a_hi(a_hi), .ad_out(ad_out), .ad_oe(ad_oe)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int cyc_len(logic [2:0] ty, bit lng);
    if (ty == 3'd0) return lng ? 6 : 4;
    return 3;
  endfunction

  function automatic logic [2:0] code_for(logic [2:0] ty);
    case (ty)
      3'd0: return 3'b011;
      3'd1: return 3'b010;
      3'd2: return 3'b001;
      3'd3: return 3'b110;
      3'd4: return 3'b101;
      3'd5: return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  task automatic m_start();
    m_act = 1; m_t = 1; m_wait = 0;
    m_ty = req_type; m_lng = req_long; m_addr = req_addr; m_wd = req_wdata;
  endtask

  task automatic m_advance();
    if (!m_act) begin
      if (req_valid) m_start();
    end else if (m_t == 2) begin
      if (!ready && m_ty < 3'd6) m_wait = 1;
      else begin m_wait = 0; m_t = 3; end
    end else if (m_t < cyc_len(m_ty, m_lng)) begin
      m_t++;
    end else begin
      m_act = 0;
      if (req_valid) m_start();
    end
  endtask

  always @(posedge clk) begin
    bit bid, win, oe;
    logic [7:0] e_ad;
    if (rst) begin
      m_act = 0; m_wait = 0; m_t = 0; m_rst = 0; m_low = 0;
    end else if (!rst_in_n) begin
      m_low++;
      if (m_low >= 3) begin m_rst = 1; m_act = 0; m_wait = 0; end
      else m_advance();
    end else begin
      m_low = 0; m_rst = 0;
      m_advance();
    end
    #4;
    if (!rst) begin
      bid  = (m_ty >= 3'd6);
      win  = m_act && (m_t == 2);
      oe   = m_act && !bid && ((m_t == 1) || ((m_ty == 3'd2 || m_ty == 3'd4) && m_t >= 2));
      e_ad = !oe ? 8'h00 : (m_t == 1) ? m_addr[7:0] : m_wd;
      chk("R10 t_state", 16'(t_state), 16'(!m_act ? 0 : (m_wait ? 7 : m_t)));
      chk("R1 status", 16'({io_m, s1, s0}), 16'(m_act ? code_for(m_ty) : 3'b000));
      chk("R2 ale", 16'(ale), 16'(m_act && !bid && m_t == 1));
      chk("R4 rd_n", 16'(rd_n), 16'(!(win && (m_ty == 3'd0 || m_ty == 3'd1 || m_ty == 3'd3))));
      chk("R4 inta_n", 16'(inta_n), 16'(!(win && m_ty == 3'd5)));
      chk("R5 wr_n", 16'(wr_n), 16'(!(win && (m_ty == 3'd2 || m_ty == 3'd4))));
      chk("R5 ad_oe", 16'(ad_oe), 16'(oe));
      chk("R5 ad_out", 16'(ad_out), 16'(e_ad));
      chk("R9 R11 a_hi", 16'(a_hi), 16'((m_act && !bid) ? m_addr[15:8] : 8'h00));
      chk("R7 rst_out", 16'(rst_out), 16'(m_rst));
      if (t_state != 3'd0) busy_n++;
      if (t_state == 3'd7) wait_n++;
    end
  end

  // one cycle; ready held low for lowr negedges after the start
  task automatic run_cyc(input logic [2:0] ty, input bit lng, input logic [15:0] addr,
                         input logic [7:0] wd, input int lowr, input int exp_busy,
                         input int exp_wait);
    @(negedge clk);
    busy_n = 0; wait_n = 0;
    req_valid = 1; req_type = ty; req_long = lng; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 0; req_addr = ~addr; req_wdata = ~wd; req_type = 3'd1;  // R11
    if (lowr > 0) begin
      ready = 0;
      repeat (lowr) @(negedge clk);
      ready = 1;
    end
    repeat (12) @(negedge clk);
    chk("R3 cycle length", 16'(busy_n), 16'(exp_busy));
    chk("R6 wait count", 16'(wait_n), 16'(exp_wait));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R10 reset t_state", 16'(t_state), 16'd0);
    chk("R10 reset strobes", 16'({rd_n, wr_n, inta_n, ale}), 16'b1110);
    chk("R10 reset rst_out", 16'(rst_out), 16'd0);

    run_cyc(3'd1, 0, 16'h1234, 8'h00, 0, 3, 0);
    run_cyc(3'd2, 0, 16'h8001, 8'hA5, 3, 5, 2);   // R6 two waits
    run_cyc(3'd3, 0, 16'h0042, 8'h00, 2, 4, 1);
    run_cyc(3'd4, 0, 16'h00C3, 8'h3C, 0, 3, 0);
    run_cyc(3'd5, 0, 16'h0038, 8'h00, 0, 3, 0);
    run_cyc(3'd5, 0, 16'h0038, 8'h00, 2, 4, 1);
    run_cyc(3'd0, 0, 16'h4000, 8'h00, 0, 4, 0);
    run_cyc(3'd0, 1, 16'hBEEF, 8'h00, 4, 9, 3);
    run_cyc(3'd6, 0, 16'hFFFF, 8'h77, 3, 3, 0);   // R6 bus idle ignores ready
    run_cyc(3'd7, 0, 16'h1111, 8'h00, 0, 3, 0);

    // R3 back-to-back: fetch then two bus idle cycles = 10 T-states
    @(negedge clk);
    busy_n = 0;
    req_valid = 1; req_type = 3'd0; req_long = 0; req_addr = 16'h2020;
    @(negedge clk);
    req_type = 3'd6;
    repeat (7) @(negedge clk);
    req_valid = 0;
    repeat (6) @(negedge clk);
    chk("R3 fetch plus two idle", 16'(busy_n), 16'd10);

    // R7 short glitch ignored
    @(negedge clk);
    req_valid = 1; req_type = 3'd1; req_addr = 16'h5A5A;
    @(negedge clk);
    req_valid = 0; ready = 0; rst_in_n = 0;
    repeat (2) @(negedge clk);
    rst_in_n = 1;
    chk("R7 glitch ignored", 16'(rst_out), 16'd0);
    ready = 1;
    repeat (10) @(negedge clk);

    // R7 accepted reset, R8 release
    @(negedge clk);
    req_valid = 1; req_type = 3'd2; req_addr = 16'h9000; req_wdata = 8'h11;
    @(negedge clk);
    req_valid = 0; rst_in_n = 0;
    repeat (3) @(negedge clk);
    chk("R7 reset taken", 16'(rst_out), 16'd1);
    chk("R7 cycle abandoned", 16'(t_state), 16'd0);
    repeat (2) @(negedge clk);
    rst_in_n = 1; req_valid = 1; req_type = 3'd3; req_addr = 16'h0055;
    @(negedge clk);
    chk("R8 rst_out falls", 16'(rst_out), 16'd0);
    chk("R8 start at release", 16'(t_state), 16'd1);
    req_valid = 0;
    repeat (8) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R3 watchdog got=hung exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule